// File: doc/BRIEF.md
# USB Endpoint Transaction Handshake Engine

This block makes the per-endpoint handshake decisions for a full-speed USB device. A packet layer hands it decoded token events (SETUP, IN, OUT) with the endpoint number addressed. For OUT and SETUP data packets it also receives the byte count, a CRC-good flag and the data PID seen on the wire. For each event the engine answers with the handshake the packet layer must send. That answer is ACK, NAK, STALL, "send a data packet" or silence. With a data packet it gives the data PID and byte count, and it also supplies the buffer start address in packet memory.

Each endpoint has its own configuration, buffer segment, payload length, arm flag, 4-bit status code and overrun flag. Firmware arms an endpoint by writing its payload length and can abort a pending transfer with a self-clearing clear-ready bit. After each transaction it reads back the status code, the overrun flag and the received or sent byte count. The number of endpoints and all field widths are parameters.

Top module: `usb_ep_engine`

## Requirements
- R1: A register write with select 1 (length) stores the payload length and arms the endpoint (status bit 5 reads 1). Reading select 1 returns the written length until an OUT or SETUP transaction completes, and then returns the received byte count.
- R2: A write with select 3 (control) whose bit 0 is 1 disarms the endpoint. Reading select 3 always returns 0.
- R3: An endpoint whose direction field (config bits [1:0]) is 00 or 11 gives response code 0 (none) to IN and OUT traffic and keeps its arm flag and status.
- R4: An IN or OUT to an enabled, non-isochronous endpoint that is not armed, or is armed for the other direction, gets NAK (code 2). An IN NAK sets status 0001, and an OUT NAK leaves the status unchanged.
- R5: A good OUT packet to an armed OUT endpoint gets ACK (code 1), disarms it and sets status 0010 for a DATA0 packet or 0110 for DATA1.
- R6: An IN to an armed IN endpoint gives code 4 (send data) with the data PID from config bit 3 and the armed length. A following host ACK toggles bit 3, sets status 0000 and disarms. Without that ACK the endpoint stays armed and a retried IN gets the same PID.
- R7: With the isochronous bit (config bit 2) set, a transfer on an armed endpoint gets no handshake (code 0 on OUT, code 4 with data on IN), disarms it and sets status 0111. An unarmed isochronous endpoint stays silent.
- R8: The overrun flag (status bit 4) is set when OUT data exceeds the armed length or SETUP data exceeds 8 bytes. It is cleared by an in-range OUT or SETUP.
- R9: With the stall bit (config bit 4) set, an enabled endpoint answers IN and OUT with STALL (code 3).
- R10: A good SETUP packet gets ACK even on a stalled endpoint. It clears the stall bit, sets config bit 3 (DATA1 next), sets status 0011 and disarms.
- R11: One cycle after a token, the buffer address reads as the endpoint's 6-bit segment (select 0) shifted left by 3. For SETUP it uses the shared segment written with select 4.
- R12: An OUT or SETUP packet with a bad CRC gets code 0 and changes no endpoint state.
- R13: The response is valid exactly one cycle after the IN token or after the end of the OUT or SETUP data packet. Status reads at select 5 as {armed, overrun, code[3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 ignored |
| tok_ep | input | EP_W | Endpoint addressed by the token |
| pkt_done | input | 1 | End of an OUT or SETUP data packet |
| pkt_len | input | LEN_W+1 | Received byte count |
| pkt_crc_ok | input | 1 | Received data CRC was good |
| pkt_data1 | input | 1 | Received packet carried DATA1 |
| host_ack | input | 1 | Host acknowledged the last IN data packet |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 send data |
| rsp_data1 | output | 1 | Data PID for code 4 (1 = DATA1) |
| rsp_len | output | LEN_W | Byte count for code 4 |
| buf_addr | output | SEG_W+3 | Buffer start address for the current token |
| reg_we | input | 1 | Register write strobe |
| reg_ep | input | EP_W | Endpoint for the write |
| reg_sel | input | 3 | Write select: 0 segment, 1 length, 2 config, 3 control, 4 SETUP segment |
| reg_wdata | input | DW | Write data |
| reg_rd_ep | input | EP_W | Endpoint for readback |
| reg_rd_sel | input | 3 | Readback select (as write, plus 5 status) |
| reg_rdata | output | DW | Readback data |

## Verification
The bench targets the corners where a handshake engine usually goes wrong. An IN retried without a host ACK must keep its PID, and a design that toggles on the token would flip it. A SETUP arriving on a stalled endpoint must be ACKed, clear the stall and force DATA1; an engine that checks the stall first would answer STALL. Oversize OUT and SETUP packets must raise overrun while still being ACKed. Bad-CRC packets and traffic to disabled or wrong-direction endpoints must leave the arm flag and status untouched. Isochronous transfers must stay silent yet still disarm, which an engine that waits for a host ACK would never do.

// File: rtl/usb_ep_pkg.sv
// Shared types and encodings for the endpoint handshake engine.
package usb_ep_pkg;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_ACK   = 3'd1,
        RSP_NAK   = 3'd2,
        RSP_STALL = 3'd3,
        RSP_DATA  = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        EV_IN_TOK     = 2'd0,
        EV_OUT_DATA   = 2'd1,
        EV_SETUP_DATA = 2'd2,
        EV_IN_ACK     = 2'd3
    } ev_e;

    localparam logic [1:0] TK_OUT   = 2'd0;
    localparam logic [1:0] TK_IN    = 2'd1;
    localparam logic [1:0] TK_SETUP = 2'd2;

    localparam logic [1:0] DIR_OUT = 2'b01;
    localparam logic [1:0] DIR_IN  = 2'b10;

    localparam logic [3:0] ST_IN_ACK   = 4'b0000;
    localparam logic [3:0] ST_IN_NAK   = 4'b0001;
    localparam logic [3:0] ST_OUT_D0   = 4'b0010;
    localparam logic [3:0] ST_SETUP    = 4'b0011;
    localparam logic [3:0] ST_OUT_D1   = 4'b0110;
    localparam logic [3:0] ST_ISO_DONE = 4'b0111;

    localparam logic [2:0] SEL_SEG   = 3'd0;
    localparam logic [2:0] SEL_LEN   = 3'd1;
    localparam logic [2:0] SEL_CFG   = 3'd2;
    localparam logic [2:0] SEL_CTRL  = 3'd3;
    localparam logic [2:0] SEL_SETUP = 3'd4;
    localparam logic [2:0] SEL_STAT  = 3'd5;

    // Endpoint configuration, bit 4 down to bit 0.
    typedef struct packed {
        logic       stall;
        logic       seq;
        logic       iso;
        logic [1:0] dir;
    } ep_cfg_t;

    // Hardware update of one endpoint after a decided event.
    typedef struct packed {
        logic       disarm;
        logic       stat_en;
        logic [3:0] stat;
        logic       ovr_en;
        logic       ovr;
        logic       len_en;
        logic       seq_en;
        logic       seq_val;
        logic       stall_clr;
    } ep_upd_t;

endpackage

// File: rtl/ep_slot.sv
// One endpoint's state: config, segment, length, arm flag, status, overrun.
// Assumes register writes and hardware updates are already steered to this
// slot; a hardware update wins over a register write in the same cycle.
module ep_slot
    import usb_ep_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int SEG_W = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             hw_en,
    input  ep_upd_t          upd,
    input  logic [LEN_W-1:0] rx_len,
    output logic             armed,
    output ep_cfg_t          cfg,
    output logic [SEG_W-1:0] seg,
    output logic [LEN_W-1:0] len,
    output logic [3:0]       stat,
    output logic             ovr
);

    localparam int CFG_W = $bits(ep_cfg_t);

    // Register writes first, then hardware updates that override them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cfg   <= '0;
            seg   <= '0;
            len   <= '0;
            stat  <= '0;
            ovr   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_SEG: seg <= wr_data[SEG_W-1:0];
                    SEL_LEN: begin
                        len   <= wr_data[LEN_W-1:0];
                        armed <= 1'b1;
                    end
                    SEL_CFG: cfg <= ep_cfg_t'(wr_data[CFG_W-1:0]);
                    SEL_CTRL: if (wr_data[0]) armed <= 1'b0;
                    default: ;
                endcase
            end
            if (hw_en) begin
                if (upd.disarm)    armed     <= 1'b0;
                if (upd.stat_en)   stat      <= upd.stat;
                if (upd.ovr_en)    ovr       <= upd.ovr;
                if (upd.len_en)    len       <= rx_len;
                if (upd.seq_en)    cfg.seq   <= upd.seq_val;
                if (upd.stall_clr) cfg.stall <= 1'b0;
            end
        end
    end

    // R1
    len_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_LEN && !(hw_en && (upd.disarm || upd.len_en)))
        |=> (armed && len == $past(wr_data[LEN_W-1:0])));

    // R2
    clr_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && wr_data[0]) |=> !armed);

    // R10
    stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && upd.stall_clr && !wr_en) |=> (!cfg.stall && cfg.seq));

    // R6
    seq_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && upd.seq_en && !upd.stall_clr && !wr_en) |=> (cfg.seq != $past(cfg.seq)));

endmodule

// File: rtl/ep_decide.sv
// Combinational handshake decision for one event on the selected endpoint.
// Assumes ev_kind is meaningful only when ev_valid is high; returns an
// all-zero update otherwise.
module ep_decide
    import usb_ep_pkg::*;
#(
    parameter int LEN_W     = 9,
    parameter int CNT_W     = LEN_W + 1,
    parameter int SETUP_MAX = 8
) (
    input  logic             ev_valid,
    input  ev_e              ev_kind,
    input  ep_cfg_t          cfg,
    input  logic             armed,
    input  logic [LEN_W-1:0] max_len,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             crc_ok,
    input  logic             rx_data1,
    output rsp_e             rsp,
    output logic             pid1,
    output logic             wait_ack,
    output ep_upd_t          upd
);

    logic disabled;
    logic over_out;
    logic over_setup;

    // Endpoint mode and length comparisons.
    always_comb begin
        disabled   = (cfg.dir != DIR_OUT) && (cfg.dir != DIR_IN);
        over_out   = rx_cnt > {1'b0, max_len};
        over_setup = rx_cnt > CNT_W'(SETUP_MAX);
    end

    // Pick the handshake and the state update for the event.
    always_comb begin
        rsp      = RSP_NONE;
        pid1     = cfg.seq;
        wait_ack = 1'b0;
        upd      = '0;
        if (ev_valid) begin
            case (ev_kind)
                EV_SETUP_DATA: begin
                    if (crc_ok) begin
                        rsp           = RSP_ACK;
                        upd.disarm    = 1'b1;
                        upd.stat_en   = 1'b1;
                        upd.stat      = ST_SETUP;
                        upd.ovr_en    = 1'b1;
                        upd.ovr       = over_setup;
                        upd.len_en    = 1'b1;
                        upd.seq_en    = 1'b1;
                        upd.seq_val   = 1'b1;
                        upd.stall_clr = 1'b1;
                    end
                end
                EV_OUT_DATA: begin
                    if (crc_ok && !disabled) begin
                        if (cfg.stall) begin
                            rsp = RSP_STALL;
                        end else if (!armed || cfg.dir != DIR_OUT) begin
                            rsp = cfg.iso ? RSP_NONE : RSP_NAK;
                        end else begin
                            rsp         = cfg.iso ? RSP_NONE : RSP_ACK;
                            upd.disarm  = 1'b1;
                            upd.stat_en = 1'b1;
                            upd.stat    = cfg.iso ? ST_ISO_DONE :
                                          (rx_data1 ? ST_OUT_D1 : ST_OUT_D0);
                            upd.ovr_en  = 1'b1;
                            upd.ovr     = over_out;
                            upd.len_en  = 1'b1;
                        end
                    end
                end
                EV_IN_TOK: begin
                    if (!disabled) begin
                        if (cfg.stall) begin
                            rsp = RSP_STALL;
                        end else if (!armed || cfg.dir != DIR_IN) begin
                            if (!cfg.iso) begin
                                rsp         = RSP_NAK;
                                upd.stat_en = 1'b1;
                                upd.stat    = ST_IN_NAK;
                            end
                        end else begin
                            rsp = RSP_DATA;
                            if (cfg.iso) begin
                                upd.disarm  = 1'b1;
                                upd.stat_en = 1'b1;
                                upd.stat    = ST_ISO_DONE;
                            end else begin
                                wait_ack = 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    upd.disarm  = 1'b1;
                    upd.stat_en = 1'b1;
                    upd.stat    = ST_IN_ACK;
                    upd.seq_en  = 1'b1;
                    upd.seq_val = !cfg.seq;
                end
            endcase
        end
    end

endmodule

// File: rtl/usb_ep_engine.sv
// Endpoint transaction handshake engine: tracks the current token, routes
// events to the addressed endpoint, registers the response and buffer address,
// and muxes register readback. Assumes at most one token, packet end or host
// ACK is meaningful per cycle and that the packet layer orders them.
module usb_ep_engine
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int LEN_W     = 9,
    parameter int SEG_W     = 6,
    parameter int DW        = 16,
    parameter int SETUP_MAX = 8,
    localparam int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int CNT_W    = LEN_W + 1,
    localparam int ADDR_W   = SEG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              pkt_done,
    input  logic [CNT_W-1:0]  pkt_len,
    input  logic              pkt_crc_ok,
    input  logic              pkt_data1,
    input  logic              host_ack,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic              rsp_data1,
    output logic [LEN_W-1:0]  rsp_len,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic              reg_we,
    input  logic [EP_W-1:0]   reg_ep,
    input  logic [2:0]        reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [EP_W-1:0]   reg_rd_ep,
    input  logic [2:0]        reg_rd_sel,
    output logic [DW-1:0]     reg_rdata
);

    localparam int CFG_W = $bits(ep_cfg_t);

    logic             armed_a [NUM_EP];
    ep_cfg_t          cfg_a   [NUM_EP];
    logic [SEG_W-1:0] seg_a   [NUM_EP];
    logic [LEN_W-1:0] len_a   [NUM_EP];
    logic [3:0]       stat_a  [NUM_EP];
    logic             ovr_a   [NUM_EP];

    logic [SEG_W-1:0] setup_seg;
    logic [EP_W-1:0]  cur_ep;
    logic             busy;
    logic             cur_setup;
    logic             in_wait;

    logic             ev_valid;
    ev_e              ev_kind;
    logic [EP_W-1:0]  ev_ep;

    rsp_e             dec_rsp;
    logic             dec_pid1;
    logic             dec_wait;
    ep_upd_t          dec_upd;
    ep_cfg_t          sel_cfg;

    // Choose the event to decide this cycle and the endpoint it touches.
    always_comb begin
        ev_valid = 1'b0;
        ev_kind  = EV_IN_TOK;
        ev_ep    = tok_ep;
        if (tok_valid && tok_kind == TK_IN) begin
            ev_valid = 1'b1;
        end else if (pkt_done && busy) begin
            ev_valid = 1'b1;
            ev_kind  = cur_setup ? EV_SETUP_DATA : EV_OUT_DATA;
            ev_ep    = cur_ep;
        end else if (host_ack && in_wait) begin
            ev_valid = 1'b1;
            ev_kind  = EV_IN_ACK;
            ev_ep    = cur_ep;
        end
    end

    assign sel_cfg = cfg_a[ev_ep];

    ep_decide #(
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .SETUP_MAX (SETUP_MAX)
    ) decide_i (
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .cfg      (sel_cfg),
        .armed    (armed_a[ev_ep]),
        .max_len  (len_a[ev_ep]),
        .rx_cnt   (pkt_len),
        .crc_ok   (pkt_crc_ok),
        .rx_data1 (pkt_data1),
        .rsp      (dec_rsp),
        .pid1     (dec_pid1),
        .wait_ack (dec_wait),
        .upd      (dec_upd)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        ep_slot #(
            .LEN_W (LEN_W),
            .SEG_W (SEG_W),
            .DW    (DW)
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && reg_ep == EP_W'(i) && reg_sel != SEL_SETUP),
            .wr_sel  (reg_sel),
            .wr_data (reg_wdata),
            .hw_en   (ev_valid && ev_ep == EP_W'(i)),
            .upd     (dec_upd),
            .rx_len  (pkt_len[LEN_W-1:0]),
            .armed   (armed_a[i]),
            .cfg     (cfg_a[i]),
            .seg     (seg_a[i]),
            .len     (len_a[i]),
            .stat    (stat_a[i]),
            .ovr     (ovr_a[i])
        );
    end

    // Shared SETUP buffer segment register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_seg <= '0;
        end else if (reg_we && reg_sel == SEL_SETUP) begin
            setup_seg <= reg_wdata[SEG_W-1:0];
        end
    end

    // Track the open transaction and latch the buffer address per token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ep    <= '0;
            busy      <= 1'b0;
            cur_setup <= 1'b0;
            in_wait   <= 1'b0;
            buf_addr  <= '0;
        end else begin
            if (tok_valid && tok_kind != 2'd3) begin
                cur_ep    <= tok_ep;
                busy      <= (tok_kind == TK_OUT) || (tok_kind == TK_SETUP);
                cur_setup <= (tok_kind == TK_SETUP);
                in_wait   <= 1'b0;
                buf_addr  <= (tok_kind == TK_SETUP) ? {setup_seg, 3'b000}
                                                    : {seg_a[tok_ep], 3'b000};
            end else begin
                if (pkt_done && busy)    busy    <= 1'b0;
                if (host_ack && in_wait) in_wait <= 1'b0;
            end
            if (ev_valid && dec_wait) in_wait <= 1'b1;
        end
    end

    // Register the handshake answer for the packet layer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NONE;
            rsp_data1 <= 1'b0;
            rsp_len   <= '0;
        end else begin
            rsp_valid <= ev_valid && ev_kind != EV_IN_ACK;
            rsp_code  <= dec_rsp;
            rsp_data1 <= dec_pid1;
            rsp_len   <= len_a[ev_ep];
        end
    end

    // Register readback mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_rd_sel)
            SEL_SEG:   reg_rdata[SEG_W-1:0] = seg_a[reg_rd_ep];
            SEL_LEN:   reg_rdata[LEN_W-1:0] = len_a[reg_rd_ep];
            SEL_CFG:   reg_rdata[CFG_W-1:0] = cfg_a[reg_rd_ep];
            SEL_SETUP: reg_rdata[SEG_W-1:0] = setup_seg;
            SEL_STAT:  reg_rdata[5:0] = {armed_a[reg_rd_ep], ovr_a[reg_rd_ep],
                                         stat_a[reg_rd_ep]};
            default:   reg_rdata = '0;
        endcase
    end

    // R13
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tok_valid || pkt_done));

    // R3
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_IN_TOK && sel_cfg.dir != DIR_IN && sel_cfg.dir != DIR_OUT)
        |=> (rsp_valid && rsp_code == RSP_NONE));

    // R9
    stall_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_IN_TOK && sel_cfg.stall &&
         (sel_cfg.dir == DIR_IN || sel_cfg.dir == DIR_OUT))
        |=> (rsp_valid && rsp_code == RSP_STALL));

endmodule

// File: tb/usb_ep_engine_tb_top.sv
`timescale 1ns/1ps
module usb_ep_engine_tb_top;

    localparam int EP_W = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic [EP_W-1:0] tok_ep = '0;
    logic       pkt_done = 1'b0;
    logic [9:0] pkt_len = '0;
    logic       pkt_crc_ok = 1'b0;
    logic       pkt_data1 = 1'b0;
    logic       host_ack = 1'b0;
    logic       rsp_valid;
    logic [2:0] rsp_code;
    logic       rsp_data1;
    logic [8:0] rsp_len;
    logic [8:0] buf_addr;
    logic       reg_we = 1'b0;
    logic [EP_W-1:0] reg_ep = '0;
    logic [2:0] reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [EP_W-1:0] reg_rd_ep = '0;
    logic [2:0] reg_rd_sel = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [2:0] code;
        logic       pid;
        logic [8:0] len;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    usb_ep_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_crc_ok(pkt_crc_ok),
        .pkt_data1(pkt_data1), .host_ack(host_ack),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data1(rsp_data1),
        .rsp_len(rsp_len), .buf_addr(buf_addr),
        .reg_we(reg_we), .reg_ep(reg_ep), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rd_ep(reg_rd_ep), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_rsp(input logic [2:0] code, input logic pid,
                              input logic [8:0] len, input string tag);
        exp_t e;
        e.code = code; e.pid = pid; e.len = len; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop one expectation per response and compare.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R13 unexpected response", int'(rsp_code), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_code == e.code, {e.tag, " code"}, int'(rsp_code), int'(e.code));
                if (e.code == 3'd4) begin
                    chk(rsp_data1 == e.pid, {e.tag, " pid"}, int'(rsp_data1), int'(e.pid));
                    chk(rsp_len == e.len, {e.tag, " len"}, int'(rsp_len), int'(e.len));
                end
            end
        end
    end

    task automatic wr(input int ep, input logic [2:0] sel, input int data);
        reg_we = 1'b1; reg_ep = EP_W'(ep); reg_sel = sel; reg_wdata = 16'(data);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ep, input logic [2:0] sel, input int exp, input string tag);
        reg_rd_ep = EP_W'(ep); reg_rd_sel = sel;
        #0.5;
        chk(reg_rdata == 16'(exp), tag, int'(reg_rdata), exp);
    endtask

    task automatic tok(input logic [1:0] kind, input int ep);
        tok_valid = 1'b1; tok_kind = kind; tok_ep = EP_W'(ep);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic pkt(input int len, input logic crc, input logic d1);
        pkt_done = 1'b1; pkt_len = 10'(len); pkt_crc_ok = crc; pkt_data1 = d1;
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    task automatic hack();
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(rsp_valid == 1'b0, "R13 reset rsp_valid", int'(rsp_valid), 0);
        rd(0, 3'd5, 'h00, "R13 reset status");
        rd(1, 3'd2, 'h00, "R3 reset config");
        chk(buf_addr == 9'd0, "R11 reset addr", int'(buf_addr), 0);

        // OUT endpoint 1, unarmed NAK and buffer address
        wr(1, 3'd2, 'h01);
        wr(1, 3'd0, 5);
        tok(2'd0, 1);
        chk(buf_addr == 9'd40, "R11 OUT addr", int'(buf_addr), 40);
        expect_rsp(3'd2, 0, 0, "R4 OUT unarmed");
        pkt(4, 1, 0);
        @(negedge clk);

        // Arm and receive DATA1
        wr(1, 3'd1, 16);
        rd(1, 3'd1, 16, "R1 length readback");
        rd(1, 3'd5, 'h20, "R1 armed flag");
        tok(2'd0, 1);
        expect_rsp(3'd1, 0, 0, "R5 OUT DATA1 ack");
        pkt(6, 1, 1);
        rd(1, 3'd5, 'h06, "R5 DATA1 status");
        rd(1, 3'd1, 6, "R1 received count");

        // Oversize OUT DATA0
        wr(1, 3'd1, 4);
        tok(2'd0, 1);
        expect_rsp(3'd1, 0, 0, "R8 OUT overrun ack");
        pkt(6, 1, 0);
        rd(1, 3'd5, 'h12, "R8 OUT overrun status");

        // Bad CRC ignored, then clear-ready
        wr(1, 3'd1, 8);
        tok(2'd0, 1);
        expect_rsp(3'd0, 0, 0, "R12 bad crc silent");
        pkt(3, 0, 0);
        rd(1, 3'd5, 'h32, "R12 state kept");
        wr(1, 3'd3, 1);
        rd(1, 3'd5, 'h12, "R2 disarmed");
        rd(1, 3'd3, 0, "R2 control reads zero");
        tok(2'd0, 1);
        expect_rsp(3'd2, 0, 0, "R4 OUT after clear");
        pkt(2, 1, 0);
        @(negedge clk);

        // IN endpoint 2 with retry and toggles
        wr(2, 3'd2, 'h02);
        wr(2, 3'd0, 2);
        wr(2, 3'd1, 10);
        expect_rsp(3'd4, 0, 10, "R6 IN data first");
        tok(2'd1, 2);
        chk(buf_addr == 9'd16, "R11 IN addr", int'(buf_addr), 16);
        expect_rsp(3'd4, 0, 10, "R6 IN retry same pid");
        tok(2'd1, 2);
        hack();
        rd(2, 3'd5, 'h00, "R6 IN ack status");
        rd(2, 3'd2, 'h0A, "R6 pid toggled");
        expect_rsp(3'd2, 0, 0, "R4 IN unarmed");
        tok(2'd1, 2);
        rd(2, 3'd5, 'h01, "R4 IN NAK status");
        wr(2, 3'd1, 3);
        expect_rsp(3'd4, 1, 3, "R6 IN DATA1");
        tok(2'd1, 2);
        hack();
        rd(2, 3'd2, 'h02, "R6 pid toggled back");

        // Wrong-direction OUT to IN endpoint
        wr(2, 3'd1, 5);
        tok(2'd0, 2);
        expect_rsp(3'd2, 0, 0, "R4 wrong direction");
        pkt(4, 1, 0);
        rd(2, 3'd5, 'h20, "R4 OUT NAK keeps status");
        wr(2, 3'd3, 1);

        // Stall then SETUP
        wr(2, 3'd2, 'h12);
        expect_rsp(3'd3, 0, 0, "R9 IN stall");
        tok(2'd1, 2);
        tok(2'd0, 2);
        expect_rsp(3'd3, 0, 0, "R9 OUT stall");
        pkt(4, 1, 0);
        wr(0, 3'd4, 9);
        tok(2'd2, 2);
        chk(buf_addr == 9'd72, "R11 SETUP addr", int'(buf_addr), 72);
        expect_rsp(3'd1, 0, 0, "R10 SETUP on stall");
        pkt(8, 1, 0);
        rd(2, 3'd5, 'h03, "R10 SETUP status");
        rd(2, 3'd2, 'h0A, "R10 stall cleared DATA1");
        tok(2'd2, 2);
        expect_rsp(3'd1, 0, 0, "R8 SETUP oversize ack");
        pkt(12, 1, 0);
        rd(2, 3'd5, 'h13, "R8 SETUP overrun");

        // Isochronous OUT and IN on endpoint 3
        wr(3, 3'd2, 'h05);
        wr(3, 3'd1, 8);
        tok(2'd0, 3);
        expect_rsp(3'd0, 0, 0, "R7 iso OUT silent");
        pkt(5, 1, 0);
        rd(3, 3'd5, 'h07, "R7 iso OUT status");
        rd(3, 3'd1, 5, "R7 iso OUT count");
        wr(3, 3'd2, 'h06);
        wr(3, 3'd1, 4);
        expect_rsp(3'd4, 0, 4, "R7 iso IN data");
        tok(2'd1, 3);
        rd(3, 3'd5, 'h07, "R7 iso IN disarmed");
        expect_rsp(3'd0, 0, 0, "R7 iso IN unarmed silent");
        tok(2'd1, 3);

        // Disabled endpoint 0 (codes 00 and 11)
        wr(0, 3'd1, 4);
        expect_rsp(3'd0, 0, 0, "R3 dir 00 IN");
        tok(2'd1, 0);
        rd(0, 3'd5, 'h20, "R3 dir 00 state kept");
        wr(0, 3'd2, 'h03);
        expect_rsp(3'd0, 0, 0, "R3 dir 11 IN");
        tok(2'd1, 0);
        tok(2'd0, 0);
        expect_rsp(3'd0, 0, 0, "R3 dir 11 OUT");
        pkt(2, 1, 0);
        rd(0, 3'd5, 'h20, "R3 dir 11 state kept");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R13 all responses seen", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule